// File: doc/BRIEF.md
# SHA-512 Block Compression Engine

This engine applies the SHA-512 compression function to one 1024-bit message block. A surrounding controller supplies a 512-bit chaining value as eight 64-bit working words and sixteen 64-bit message words, then pulses a start strobe. The engine returns the new chaining value together with a one-cycle completion strobe. Message padding, length encoding, memory traffic and the chaining of several blocks are left to the caller, which feeds each result back in as the next chaining value.

Inside, one round runs per clock. The message schedule is not stored as 80 expanded words. It lives in a 16-word ring that is rewritten in place during a dedicated 16-cycle refresh phase. That phase follows each group of 16 rounds except the last. The 80 round constants come from an internal ROM. The feed-forward addition of the saved chaining value is folded into the clock edge of the final round.

Top module: `sha512_core`

## Requirements
- R1: While reset is held, and right after it is released, `done` is 0 and `hash_out` is all zeros.
- R2: A start taken while the engine is idle makes `done` rise exactly 144 clock edges after the accepting edge. This covers 80 round cycles and four 16-cycle schedule refreshes, one after each of rounds 16, 32, 48 and 64. The round counter does not advance during a refresh.
- R3: `done` is high for exactly one cycle per compression.
- R4: `hash_out` changes only on the edge that raises `done`. It holds its value in every other cycle, including during the next compression.
- R5: A start asserted while a compression is in progress is ignored. The running result and its latency are unaffected.
- R6: Word i of `chain_in`, `msg_in` and `hash_out` occupies bits [64*i+63:64*i], and word 0 is the first word in big-endian order. Compressing the padded empty message from the standard initial hash value gives the standard empty-message digest.
- R7: Compressing the padded three-byte message "abc" gives the standard "abc" digest. In that block, word 0 is 0x6162638000000000 and word 15 is 0x18.
- R8: For any chaining value and message block, the result equals the standard compression function. That function is 80 rounds over an expanded schedule using the big and small sigma functions, Ch and Maj, with each working word then added modulo 2^64 to the input chaining word.
- R9: A start asserted in the cycle where `done` is high is accepted, and it begins a new compression with full latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a compression; sampled only when idle |
| chain_in | input | 512 | Input chaining value, eight 64-bit words |
| msg_in | input | 1024 | Message block, sixteen 64-bit words |
| hash_out | output | 512 | Updated chaining value, eight 64-bit words |
| done | output | 1 | One-cycle pulse when `hash_out` is updated |

## Verification
The hardest case to reach is a start strobe that lands in the middle of a schedule refresh or a round group. Such a strobe must leave both the ring contents and the round counter untouched. To reach it, some runs pulse start with unrelated random data every seventh cycle during the compression, so strobes fall in both phases. Those runs still demand the exact digest and the 144-edge latency. A second hard case is the back-to-back start that coincides with `done`. The bench reaches it by launching the next block from the very cycle it observes the completion pulse. Random blocks are compared with a bench model that expands all 80 schedule words the conventional way. That comparison exercises the in-place ring update order independently.

// File: rtl/sha512_pkg.sv
package sha512_pkg;

  localparam int WORD_W = 64;
  localparam int NWORK  = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NWORK-1:0][WORD_W-1:0] work_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_ROUND,
    ENG_REFRESH
  } eng_e;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_sig_a(input word_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic word_t big_sig_e(input word_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic word_t small_sig0(input word_t x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic word_t small_sig1(input word_t x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  function automatic word_t choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majority(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic work_t work_add(input work_t p, input work_t q);
    work_t r;
    for (int i = 0; i < NWORK; i++) begin
      r[i] = p[i] + q[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/sha512_krom.sv
module sha512_krom
  import sha512_pkg::*;
#(
  parameter int ROUNDS = 80
) (
  input  logic [$clog2(ROUNDS)-1:0] idx,
  output word_t                     kval
);

  localparam int IW   = $clog2(ROUNDS);
  localparam int HALF = 40;

  function automatic word_t k_lo(input logic [5:0] i);
    word_t k;
    case (i)
      6'd0:  k = 64'h428a2f98d728ae22;  6'd1:  k = 64'h7137449123ef65cd;
      6'd2:  k = 64'hb5c0fbcfec4d3b2f;  6'd3:  k = 64'he9b5dba58189dbbc;
      6'd4:  k = 64'h3956c25bf348b538;  6'd5:  k = 64'h59f111f1b605d019;
      6'd6:  k = 64'h923f82a4af194f9b;  6'd7:  k = 64'hab1c5ed5da6d8118;
      6'd8:  k = 64'hd807aa98a3030242;  6'd9:  k = 64'h12835b0145706fbe;
      6'd10: k = 64'h243185be4ee4b28c;  6'd11: k = 64'h550c7dc3d5ffb4e2;
      6'd12: k = 64'h72be5d74f27b896f;  6'd13: k = 64'h80deb1fe3b1696b1;
      6'd14: k = 64'h9bdc06a725c71235;  6'd15: k = 64'hc19bf174cf692694;
      6'd16: k = 64'he49b69c19ef14ad2;  6'd17: k = 64'hefbe4786384f25e3;
      6'd18: k = 64'h0fc19dc68b8cd5b5;  6'd19: k = 64'h240ca1cc77ac9c65;
      6'd20: k = 64'h2de92c6f592b0275;  6'd21: k = 64'h4a7484aa6ea6e483;
      6'd22: k = 64'h5cb0a9dcbd41fbd4;  6'd23: k = 64'h76f988da831153b5;
      6'd24: k = 64'h983e5152ee66dfab;  6'd25: k = 64'ha831c66d2db43210;
      6'd26: k = 64'hb00327c898fb213f;  6'd27: k = 64'hbf597fc7beef0ee4;
      6'd28: k = 64'hc6e00bf33da88fc2;  6'd29: k = 64'hd5a79147930aa725;
      6'd30: k = 64'h06ca6351e003826f;  6'd31: k = 64'h142929670a0e6e70;
      6'd32: k = 64'h27b70a8546d22ffc;  6'd33: k = 64'h2e1b21385c26c926;
      6'd34: k = 64'h4d2c6dfc5ac42aed;  6'd35: k = 64'h53380d139d95b3df;
      6'd36: k = 64'h650a73548baf63de;  6'd37: k = 64'h766a0abb3c77b2a8;
      6'd38: k = 64'h81c2c92e47edaee6;  6'd39: k = 64'h92722c851482353b;
      default: k = '0;
    endcase
    return k;
  endfunction

  function automatic word_t k_hi(input logic [5:0] i);
    word_t k;
    case (i)
      6'd0:  k = 64'ha2bfe8a14cf10364;  6'd1:  k = 64'ha81a664bbc423001;
      6'd2:  k = 64'hc24b8b70d0f89791;  6'd3:  k = 64'hc76c51a30654be30;
      6'd4:  k = 64'hd192e819d6ef5218;  6'd5:  k = 64'hd69906245565a910;
      6'd6:  k = 64'hf40e35855771202a;  6'd7:  k = 64'h106aa07032bbd1b8;
      6'd8:  k = 64'h19a4c116b8d2d0c8;  6'd9:  k = 64'h1e376c085141ab53;
      6'd10: k = 64'h2748774cdf8eeb99;  6'd11: k = 64'h34b0bcb5e19b48a8;
      6'd12: k = 64'h391c0cb3c5c95a63;  6'd13: k = 64'h4ed8aa4ae3418acb;
      6'd14: k = 64'h5b9cca4f7763e373;  6'd15: k = 64'h682e6ff3d6b2b8a3;
      6'd16: k = 64'h748f82ee5defb2fc;  6'd17: k = 64'h78a5636f43172f60;
      6'd18: k = 64'h84c87814a1f0ab72;  6'd19: k = 64'h8cc702081a6439ec;
      6'd20: k = 64'h90befffa23631e28;  6'd21: k = 64'ha4506cebde82bde9;
      6'd22: k = 64'hbef9a3f7b2c67915;  6'd23: k = 64'hc67178f2e372532b;
      6'd24: k = 64'hca273eceea26619c;  6'd25: k = 64'hd186b8c721c0c207;
      6'd26: k = 64'heada7dd6cde0eb1e;  6'd27: k = 64'hf57d4f7fee6ed178;
      6'd28: k = 64'h06f067aa72176fba;  6'd29: k = 64'h0a637dc5a2c898a6;
      6'd30: k = 64'h113f9804bef90dae;  6'd31: k = 64'h1b710b35131c471b;
      6'd32: k = 64'h28db77f523047d84;  6'd33: k = 64'h32caab7b40c72493;
      6'd34: k = 64'h3c9ebe0a15c9bebc;  6'd35: k = 64'h431d67c49c100d4c;
      6'd36: k = 64'h4cc5d4becb3e42b6;  6'd37: k = 64'h597f299cfc657e2a;
      6'd38: k = 64'h5fcb6fab3ad6faec;  6'd39: k = 64'h6c44198c4a475817;
      default: k = '0;
    endcase
    return k;
  endfunction

  logic             in_low;
  logic [IW-1:0]    hi_off;

  assign in_low = (idx < IW'(HALF));
  assign hi_off = idx - IW'(HALF);
  assign kval   = in_low ? k_lo(6'(idx)) : k_hi(6'(hi_off));

endmodule

// File: rtl/sha512_sched.sv
module sha512_sched
  import sha512_pkg::*;
#(
  parameter int WIN = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [WIN*WORD_W-1:0]    load_msg,
  input  logic                     upd_en,
  input  logic [$clog2(WIN)-1:0]   upd_idx,
  input  logic [$clog2(WIN)-1:0]   rd_idx,
  output word_t                    rd_word
);

  localparam int IW = $clog2(WIN);

  word_t           ring_q [WIN];
  word_t           upd_val;
  logic [IW-1:0]   idx_lag7;
  logic [IW-1:0]   idx_next;
  logic [IW-1:0]   idx_lag2;

  assign idx_lag7 = upd_idx + IW'(9);
  assign idx_next = upd_idx + IW'(1);
  assign idx_lag2 = upd_idx + IW'(14);

  always_comb begin
    upd_val = ring_q[upd_idx] + ring_q[idx_lag7]
            + small_sig0(ring_q[idx_next]) + small_sig1(ring_q[idx_lag2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) begin
        ring_q[i] <= '0;
      end
    end else if (load) begin
      for (int i = 0; i < WIN; i++) begin
        ring_q[i] <= load_msg[i*WORD_W +: WORD_W];
      end
    end else if (upd_en) begin
      ring_q[upd_idx] <= upd_val;
    end
  end

  assign rd_word = ring_q[rd_idx];

endmodule

// File: rtl/sha512_round.sv
module sha512_round
  import sha512_pkg::*;
(
  input  work_t cur,
  input  word_t kc,
  input  word_t wm,
  output work_t nxt
);

  word_t t_mix;
  word_t t_head;

  assign t_mix  = cur[7] + big_sig_e(cur[4]) + choose(cur[4], cur[5], cur[6]) + kc + wm;
  assign t_head = big_sig_a(cur[0]) + majority(cur[0], cur[1], cur[2]);

  always_comb begin
    nxt[0] = t_mix + t_head;
    nxt[1] = cur[0];
    nxt[2] = cur[1];
    nxt[3] = cur[2];
    nxt[4] = cur[3] + t_mix;
    nxt[5] = cur[4];
    nxt[6] = cur[5];
    nxt[7] = cur[6];
  end

endmodule

// File: rtl/sha512_core.sv
module sha512_core
  import sha512_pkg::*;
#(
  parameter int ROUNDS = 80,
  parameter int WIN    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NWORK*WORD_W-1:0]   chain_in,
  input  logic [WIN*WORD_W-1:0]     msg_in,
  output logic [NWORK*WORD_W-1:0]   hash_out,
  output logic                      done
);

  localparam int RIDX_W = $clog2(ROUNDS);
  localparam int WIDX_W = $clog2(WIN);
  localparam logic [RIDX_W-1:0] LAST_RND = RIDX_W'(ROUNDS - 1);

  eng_e                 st_q;
  work_t                work_q;
  work_t                save_q;
  work_t                work_nx;
  logic [RIDX_W-1:0]    ridx_q;
  logic [WIDX_W-1:0]    fidx_q;
  logic [NWORK*WORD_W-1:0] hash_q;
  logic                 done_q;
  word_t                k_cur;
  word_t                w_cur;

  logic busy;
  logic accept;
  logic round_fire;
  logic refresh_fire;
  logic last_round;
  logic group_end;
  logic refresh_end;

  assign busy         = (st_q != ENG_IDLE);
  assign accept       = start && !busy;
  assign round_fire   = (st_q == ENG_ROUND);
  assign refresh_fire = (st_q == ENG_REFRESH);
  assign last_round   = round_fire && (ridx_q == LAST_RND);
  assign group_end    = round_fire && (&ridx_q[WIDX_W-1:0]) && !last_round;
  assign refresh_end  = refresh_fire && (&fidx_q);

  sha512_krom #(.ROUNDS(ROUNDS)) u_krom (
    .idx  (ridx_q),
    .kval (k_cur)
  );

  sha512_sched #(.WIN(WIN)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_msg (msg_in),
    .upd_en   (refresh_fire),
    .upd_idx  (fidx_q),
    .rd_idx   (ridx_q[WIDX_W-1:0]),
    .rd_word  (w_cur)
  );

  sha512_round u_round (
    .cur (work_q),
    .kc  (k_cur),
    .wm  (w_cur),
    .nxt (work_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      work_q <= '0;
      save_q <= '0;
      ridx_q <= '0;
      fidx_q <= '0;
      hash_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ENG_IDLE: begin
          if (start) begin
            work_q <= chain_in;
            save_q <= chain_in;
            ridx_q <= '0;
            st_q   <= ENG_ROUND;
          end
        end
        ENG_ROUND: begin
          work_q <= work_nx;
          ridx_q <= ridx_q + RIDX_W'(1);
          if (last_round) begin
            hash_q <= work_add(save_q, work_nx);
            done_q <= 1'b1;
            st_q   <= ENG_IDLE;
          end else if (group_end) begin
            fidx_q <= '0;
            st_q   <= ENG_REFRESH;
          end
        end
        ENG_REFRESH: begin
          fidx_q <= fidx_q + WIDX_W'(1);
          if (refresh_end) begin
            st_q <= ENG_ROUND;
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign hash_out = hash_q;
  assign done     = done_q;

endmodule

// File: rtl/sha512_core_chk.sv
module sha512_core_chk #(
  parameter int ROUNDS = 80,
  parameter int WIN    = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic                       refreshing,
  input logic [$clog2(ROUNDS)-1:0]  round_idx,
  input logic [511:0]               hash_out
);

  localparam int LAT   = ROUNDS + ((ROUNDS - 1) / WIN) * WIN;
  localparam int CNT_W = 16;

  logic [CNT_W-1:0] cnt_q;
  logic             trk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      trk_q <= 1'b0;
    end else if (start && !busy) begin
      cnt_q <= '0;
      trk_q <= 1'b1;
    end else begin
      if (trk_q) cnt_q <= cnt_q + CNT_W'(1);
      if (done)  trk_q <= 1'b0;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trk_q && cnt_q == CNT_W'(LAT))); // R2

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2

  AST_REFRESH_HOLDS_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (refreshing && $past(refreshing)) |-> $stable(round_idx)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(hash_out)); // R4

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

endmodule

bind sha512_core sha512_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .refreshing (refresh_fire),
  .round_idx  (ridx_q),
  .hash_out   (hash_out)
);

// File: tb/sha512_core_bench.sv
module sha512_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_LAT    = 144;
  localparam int WATCHDOG   = 100000;
  localparam int N_RANDOM   = 24;

  localparam logic [511:0] IV = {
    64'h5be0cd19137e2179, 64'h1f83d9abfb41bd6b, 64'h9b05688c2b3e6c1f, 64'h510e527fade682d1,
    64'ha54ff53a5f1d36f1, 64'h3c6ef372fe94f82b, 64'hbb67ae8584caa73b, 64'h6a09e667f3bcc908};
  localparam logic [511:0] DIG_EMPTY = {
    64'ha538327af927da3e, 64'h63b931bd47417a81, 64'hff8318d2877eec2f, 64'h47d0d13c5d85f2b0,
    64'h83f4a921d36ce9ce, 64'hd620e4050b5715dc, 64'hf1542850d66d8007, 64'hcf83e1357eefb8bd};
  localparam logic [511:0] DIG_ABC = {
    64'h2a9ac94fa54ca49f, 64'h454d4423643ce80e, 64'h36ba3c23a3feebbd, 64'h2192992a274fc1a8,
    64'h0a9eeee64b55d39a, 64'h12e6fa4e89a97ea2, 64'hcc417349ae204131, 64'hddaf35a193617aba};

  localparam logic [63:0] KB_LO [40] = '{
    64'h428a2f98d728ae22, 64'h7137449123ef65cd, 64'hb5c0fbcfec4d3b2f, 64'he9b5dba58189dbbc,
    64'h3956c25bf348b538, 64'h59f111f1b605d019, 64'h923f82a4af194f9b, 64'hab1c5ed5da6d8118,
    64'hd807aa98a3030242, 64'h12835b0145706fbe, 64'h243185be4ee4b28c, 64'h550c7dc3d5ffb4e2,
    64'h72be5d74f27b896f, 64'h80deb1fe3b1696b1, 64'h9bdc06a725c71235, 64'hc19bf174cf692694,
    64'he49b69c19ef14ad2, 64'hefbe4786384f25e3, 64'h0fc19dc68b8cd5b5, 64'h240ca1cc77ac9c65,
    64'h2de92c6f592b0275, 64'h4a7484aa6ea6e483, 64'h5cb0a9dcbd41fbd4, 64'h76f988da831153b5,
    64'h983e5152ee66dfab, 64'ha831c66d2db43210, 64'hb00327c898fb213f, 64'hbf597fc7beef0ee4,
    64'hc6e00bf33da88fc2, 64'hd5a79147930aa725, 64'h06ca6351e003826f, 64'h142929670a0e6e70,
    64'h27b70a8546d22ffc, 64'h2e1b21385c26c926, 64'h4d2c6dfc5ac42aed, 64'h53380d139d95b3df,
    64'h650a73548baf63de, 64'h766a0abb3c77b2a8, 64'h81c2c92e47edaee6, 64'h92722c851482353b};
  localparam logic [63:0] KB_HI [40] = '{
    64'ha2bfe8a14cf10364, 64'ha81a664bbc423001, 64'hc24b8b70d0f89791, 64'hc76c51a30654be30,
    64'hd192e819d6ef5218, 64'hd69906245565a910, 64'hf40e35855771202a, 64'h106aa07032bbd1b8,
    64'h19a4c116b8d2d0c8, 64'h1e376c085141ab53, 64'h2748774cdf8eeb99, 64'h34b0bcb5e19b48a8,
    64'h391c0cb3c5c95a63, 64'h4ed8aa4ae3418acb, 64'h5b9cca4f7763e373, 64'h682e6ff3d6b2b8a3,
    64'h748f82ee5defb2fc, 64'h78a5636f43172f60, 64'h84c87814a1f0ab72, 64'h8cc702081a6439ec,
    64'h90befffa23631e28, 64'ha4506cebde82bde9, 64'hbef9a3f7b2c67915, 64'hc67178f2e372532b,
    64'hca273eceea26619c, 64'hd186b8c721c0c207, 64'heada7dd6cde0eb1e, 64'hf57d4f7fee6ed178,
    64'h06f067aa72176fba, 64'h0a637dc5a2c898a6, 64'h113f9804bef90dae, 64'h1b710b35131c471b,
    64'h28db77f523047d84, 64'h32caab7b40c72493, 64'h3c9ebe0a15c9bebc, 64'h431d67c49c100d4c,
    64'h4cc5d4becb3e42b6, 64'h597f299cfc657e2a, 64'h5fcb6fab3ad6faec, 64'h6c44198c4a475817};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [511:0]  chain_in = '0;
  logic [1023:0] msg_in = '0;
  logic [511:0]  hash_out;
  logic          done;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  logic [511:0] prev_hash = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha512_core u_sha512_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .chain_in (chain_in),
    .msg_in   (msg_in),
    .hash_out (hash_out),
    .done     (done)
  );

  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [63:0] kb(input int t);
    return (t < 40) ? KB_LO[t] : KB_HI[t-40];
  endfunction

  function automatic logic [511:0] ref_compress(input logic [511:0] cv, input logic [1023:0] m);
    logic [63:0] w [80];
    logic [63:0] v [8];
    logic [63:0] t1, t2;
    logic [511:0] res;
    for (int t = 0; t < 16; t++) w[t] = m[64*t +: 64];
    for (int t = 16; t < 80; t++) begin
      w[t] = (rr(w[t-2], 19) ^ rr(w[t-2], 61) ^ (w[t-2] >> 6)) + w[t-7]
           + (rr(w[t-15], 1) ^ rr(w[t-15], 8) ^ (w[t-15] >> 7)) + w[t-16];
    end
    for (int i = 0; i < 8; i++) v[i] = cv[64*i +: 64];
    for (int t = 0; t < 80; t++) begin
      t1 = v[7] + (rr(v[4], 14) ^ rr(v[4], 18) ^ rr(v[4], 41))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kb(t) + w[t];
      t2 = (rr(v[0], 28) ^ rr(v[0], 34) ^ rr(v[0], 39))
         + ((v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) res[64*i +: 64] = cv[64*i +: 64] + v[i];
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // called at a falling edge; accepting edge is the next rising edge
  task automatic launch(input logic [511:0] cv, input logic [1023:0] m);
    chain_in = cv;
    msg_in   = m;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat   = 0;
  endtask

  task automatic wait_done(input bit interfere);
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
      if (lat == 72)
        check(hash_out == prev_hash, "R4 result held during run", hash_out, prev_hash);
      if (interfere && lat < EXP_LAT - 4 && (lat % 7) == 3) begin
        start = 1'b1;
        for (int i = 0; i < 16; i++) chain_in[32*i +: 32] = $urandom;
        for (int i = 0; i < 32; i++) msg_in[32*i +: 32] = $urandom;
      end else begin
        start = 1'b0;
      end
    end
  endtask

  function automatic logic [1023:0] rand_block();
    logic [1023:0] b;
    for (int i = 0; i < 32; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected <%0d cycles", WATCHDOG, WATCHDOG);
    summary();
  end

  initial begin
    logic [1023:0] m_empty;
    logic [1023:0] m_abc;
    logic [511:0]  cv;
    logic [1023:0] m;
    logic [511:0]  exp_h;

    void'($urandom(32'h5eed_0512));
    m_empty = '0;
    m_empty[63:0] = 64'h8000000000000000;
    m_abc = '0;
    m_abc[63:0] = 64'h6162638000000000;
    m_abc[1023:960] = 64'h18;

    // R1: reset values while held and right after release
    repeat (3) @(negedge clk);
    check(done == 1'b0 && hash_out == '0, "R1 reset held", {hash_out[510:0], done}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && hash_out == '0, "R1 after release", {hash_out[510:0], done}, '0);

    // R6 empty message, R2 latency, R3 pulse, R4 hold
    launch(IV, m_empty);
    wait_done(1'b0);
    check(lat == EXP_LAT, "R2 latency empty", 512'(lat), 512'(EXP_LAT));
    check(hash_out == DIG_EMPTY, "R6 empty digest", hash_out, DIG_EMPTY);
    prev_hash = hash_out;
    @(negedge clk);
    check(done == 1'b0, "R3 done one cycle", 512'(done), '0);
    repeat (5) @(negedge clk);
    check(hash_out == prev_hash && !done, "R4 result held idle", hash_out, prev_hash);

    // R7 abc digest with R5 interfering starts
    launch(IV, m_abc);
    wait_done(1'b1);
    check(lat == EXP_LAT, "R5 latency with starts while busy", 512'(lat), 512'(EXP_LAT));
    check(hash_out == DIG_ABC, "R7 abc digest (R5 ignored starts)", hash_out, DIG_ABC);
    prev_hash = hash_out;

    // R9 back-to-back: start in the done cycle
    @(negedge clk);
    launch(IV, m_empty);
    wait_done(1'b0);
    check(hash_out == DIG_EMPTY, "R9 first of pair", hash_out, DIG_EMPTY);
    prev_hash = hash_out;
    launch(IV, m_abc);
    wait_done(1'b0);
    check(lat == EXP_LAT, "R9 latency back-to-back", 512'(lat), 512'(EXP_LAT));
    check(hash_out == DIG_ABC, "R9 second of pair", hash_out, DIG_ABC);
    prev_hash = hash_out;
    @(negedge clk);

    // R8 directed corners then constrained random blocks
    for (int it = 0; it < N_RANDOM; it++) begin
      if (it == 0) begin
        cv = '0; m = '0;
      end else if (it == 1) begin
        cv = '1; m = '1;
      end else if (it == 2) begin
        cv = prev_hash; m = m_abc;
      end else begin
        cv = rand_block()[511:0];
        m  = rand_block();
      end
      exp_h = ref_compress(cv, m);
      launch(cv, m);
      wait_done(it % 3 == 0);
      check(lat == EXP_LAT, "R2 latency random", 512'(lat), 512'(EXP_LAT));
      check(hash_out == exp_h, "R8 random compression", hash_out, exp_h);
      prev_hash = hash_out;
      @(negedge clk);
      check(done == 1'b0, "R3 done one cycle random", 512'(done), '0);
    end

    summary();
  end

endmodule